// File: doc/BRIEF.md
# Privileged Status Register Unit

This block carries out the instructions of a small 16/32-bit processor core that act on the status word and on the user stack pointer. The core's decoder picks an operation class, starts the block, and supplies the opcode word and an operand or immediate word that were already fetched. It also supplies the current supervisor flag, the contents of the selected address register, and an effective-address cost.

One clock after `start`, the block raises `done` for a single cycle. In that cycle it shows the cycle cost of the operation, any program-counter step, and an optional write-back of the status word or the user stack pointer. The 16-bit status register and the 32-bit user stack pointer are kept inside the block, and their current values are always visible on outputs.

Some operations are privileged. If one of them is tried without supervisor rights, the block raises `priv_fault` together with `done` and changes nothing. Effective-address calculation, bus traffic and the exception entry sequence are left to the surrounding core.

Top module: `priv_sr_unit`

## Requirements
- R1: During and after reset, `sr` equals SR_RESET (default 16'h2700), `usp` is 0, and `done`, `priv_fault` and `wb_valid` are low.
- R2: A `start` sampled at a clock edge gives `done` high for exactly the following cycle, with `cycles` valid. Without `start`, `done` is low.
- R3: Class 0 (full status write) loads `sr` with `operand` and costs 12 + `ea_cost` cycles.
- R4: Class 1 (status read-out) needs no privilege. It returns `wb_valid`=1, `wb_to_areg`=0, `wb_data` = `sr` zero-extended, and `wb_reg` = opcode[2:0]. It costs 6 cycles when opcode[5:3] is 0 and 8 + `ea_cost` otherwise.
- R5: Class 2 (condition-code write) needs no privilege. It keeps `sr[15:8]`, puts `operand[7:0]` into `sr[7:0]`, and costs 12 + `ea_cost` cycles.
- R6: Class 3 (user stack pointer transfer) costs 4 cycles. If opcode bit 3 is 0, `usp` takes `areg_in`. If it is 1, the block gives `wb_valid`=1, `wb_to_areg`=1, `wb_reg` = opcode[2:0] and `wb_data` = `usp`, and `usp` stays as it was.
- R7: Classes 4, 5 and 6 combine `sr` with `operand` by AND, OR and XOR respectively. Each costs 20 cycles and reports `pc_adv`=2. All other classes report `pc_adv`=0.
- R8: Classes 0, 3, 4, 5 and 6 with `supervisor`=0 give `priv_fault`=1 with `done`, `cycles`=0, no write-back, `pc_adv`=0, and `sr` and `usp` unchanged.
- R9: Class 7 is reserved. It gives `done` with `cycles`=0 and changes no state.
- R10: Starts in consecutive cycles are each completed. Every operation sees the state that the one before it left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation this cycle |
| op_class | input | 3 | Operation class 0..7 |
| opcode | input | 16 | Opcode word (mode 5:3, register 2:0, direction bit 3) |
| operand | input | SRW | Fetched operand or immediate word |
| supervisor | input | 1 | Current supervisor flag |
| areg_in | input | AW | Value of the selected address register |
| ea_cost | input | EAW | Effective-address cycle cost |
| sr | output | SRW | Status register |
| usp | output | AW | User stack pointer |
| done | output | 1 | One-cycle completion pulse |
| cycles | output | CW | Cycle cost of the completed operation |
| priv_fault | output | 1 | Privilege violation request |
| pc_adv | output | 3 | Program counter advance in bytes |
| wb_valid | output | 1 | Write-back strobe |
| wb_to_areg | output | 1 | Write-back goes to an address register (else to the operand destination) |
| wb_reg | output | 3 | Register number of the write-back |
| wb_data | output | AW | Write-back value |

## Verification
A new start can arrive in the same cycle as the completion of the previous operation. When that happens, the new operation must read the status register or stack pointer that the previous one has just written. The bench provokes this by keeping `start` high through whole sweeps of classes, modes, costs and privilege states. It checks every completion against a bench-side model that is updated in program order. A stale read therefore shows up as a status or write-back mismatch in the next cycle.

// File: rtl/priv_sr_unit.sv
module priv_sr_unit #(
  parameter int SRW = 16,
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int EAW = 4,
  parameter logic [15:0] SR_RESET = 16'h2700
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [2:0]     op_class,
  input  logic [15:0]    opcode,
  input  logic [SRW-1:0] operand,
  input  logic           supervisor,
  input  logic [AW-1:0]  areg_in,
  input  logic [EAW-1:0] ea_cost,
  output logic [SRW-1:0] sr,
  output logic [AW-1:0]  usp,
  output logic           done,
  output logic [CW-1:0]  cycles,
  output logic           priv_fault,
  output logic [2:0]     pc_adv,
  output logic           wb_valid,
  output logic           wb_to_areg,
  output logic [2:0]     wb_reg,
  output logic [AW-1:0]  wb_data
);
  localparam logic [2:0] C_SRW = 3'd0, C_SRR = 3'd1, C_CCR = 3'd2, C_USP = 3'd3,
                         C_AND = 3'd4, C_OR  = 3'd5, C_XOR = 3'd6;
  localparam int HB = SRW / 2;

  wire [2:0]    ea_mode = opcode[5:3];
  wire          to_an   = opcode[3];
  wire [CW-1:0] ea_c    = CW'(ea_cost);
  wire          needs_s = (op_class == C_SRW) || (op_class == C_USP) ||
                          (op_class == C_AND) || (op_class == C_OR) || (op_class == C_XOR);
  wire          fault   = needs_s && !supervisor;

  logic [2:0] op_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= SRW'(SR_RESET);
      usp <= '0;
      done <= 1'b0;
      cycles <= '0;
      priv_fault <= 1'b0;
      pc_adv <= '0;
      wb_valid <= 1'b0;
      wb_to_areg <= 1'b0;
      wb_reg <= '0;
      wb_data <= '0;
      op_q <= '0;
    end else begin
      done <= start;
      priv_fault <= 1'b0;
      wb_valid <= 1'b0;
      pc_adv <= '0;
      if (start) begin
        op_q <= op_class;
        cycles <= '0;
        wb_to_areg <= 1'b0;
        wb_reg <= opcode[2:0];
        if (fault) begin
          priv_fault <= 1'b1;
        end else begin
          case (op_class)
            C_SRW: begin
              sr <= operand;
              cycles <= CW'(12) + ea_c;
            end
            C_SRR: begin
              wb_valid <= 1'b1;
              wb_data <= AW'(sr);
              cycles <= (ea_mode == 3'd0) ? CW'(6) : CW'(8) + ea_c;
            end
            C_CCR: begin
              sr <= {sr[SRW-1:HB], operand[HB-1:0]};
              cycles <= CW'(12) + ea_c;
            end
            C_USP: begin
              cycles <= CW'(4);
              if (to_an) begin
                wb_valid <= 1'b1;
                wb_to_areg <= 1'b1;
                wb_data <= usp;
              end else begin
                usp <= areg_in;
              end
            end
            C_AND, C_OR, C_XOR: begin
              cycles <= CW'(20);
              pc_adv <= 3'd2;
              sr <= (op_class == C_AND) ? (sr & operand) :
                    (op_class == C_OR)  ? (sr | operand) : (sr ^ operand);
            end
            default: ;
          endcase
        end
      end
    end
  end

  p_done_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  p_done_needs_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));
  p_fault_freezes_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |-> (done && !wb_valid && cycles == '0 && $stable(sr) && $stable(usp)));
  p_ccr_keeps_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == C_CCR) |-> sr[SRW-1:HB] == $past(sr[SRW-1:HB]));
  p_usp_cost_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == C_USP && !priv_fault) |-> cycles == CW'(4));
  p_logic_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_adv != 3'd0) |-> (done && cycles == CW'(20) && pc_adv == 3'd2));
  p_reserved_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == 3'd7) |-> (cycles == '0 && !wb_valid && !priv_fault && $stable(sr) && $stable(usp)));
endmodule

// File: tb/priv_sr_unit_bench.sv
module priv_sr_unit_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start, supervisor;
  logic [2:0]  op_class;
  logic [15:0] opcode, operand;
  logic [31:0] areg_in;
  logic [3:0]  ea_cost;
  logic [15:0] sr;
  logic [31:0] usp, wb_data;
  logic        done, priv_fault, wb_valid, wb_to_areg;
  logic [7:0]  cycles;
  logic [2:0]  pc_adv, wb_reg;

  priv_sr_unit u_priv_sr_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_class(op_class), .opcode(opcode),
    .operand(operand), .supervisor(supervisor), .areg_in(areg_in), .ea_cost(ea_cost),
    .sr(sr), .usp(usp), .done(done), .cycles(cycles), .priv_fault(priv_fault),
    .pc_adv(pc_adv), .wb_valid(wb_valid), .wb_to_areg(wb_to_areg), .wb_reg(wb_reg),
    .wb_data(wb_data));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [15:0] m_sr;
  logic [31:0] m_usp;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] oc, input logic [15:0] opw, input logic [15:0] opd,
                        input logic sup, input logic [31:0] ar, input logic [3:0] ec);
    logic f, e_wb, e_an;
    logic [7:0] e_cyc;
    logic [2:0] e_pc;
    logic [31:0] e_wbd;
    f = (oc == 0 || oc == 3 || oc == 4 || oc == 5 || oc == 6) && !sup;
    e_cyc = 0; e_pc = 0; e_wb = 0; e_an = 0; e_wbd = 0;
    if (!f) begin
      case (oc)
        3'd0: begin m_sr = opd; e_cyc = 12 + ec; end
        3'd1: begin e_wb = 1; e_wbd = {16'h0, m_sr}; e_cyc = (opw[5:3] == 0) ? 8'd6 : 8 + ec; end
        3'd2: begin m_sr = {m_sr[15:8], opd[7:0]}; e_cyc = 12 + ec; end
        3'd3: begin
          e_cyc = 4;
          if (opw[3]) begin e_wb = 1; e_an = 1; e_wbd = m_usp; end
          else m_usp = ar;
        end
        3'd4: begin m_sr = m_sr & opd; e_cyc = 20; e_pc = 2; end
        3'd5: begin m_sr = m_sr | opd; e_cyc = 20; e_pc = 2; end
        3'd6: begin m_sr = m_sr ^ opd; e_cyc = 20; e_pc = 2; end
        default: ;
      endcase
    end
    op_class = oc; opcode = opw; operand = opd; supervisor = sup; areg_in = ar; ea_cost = ec;
    start = 1;
    @(negedge clk);
    chk(done === 1'b1, "R2 done", 32'(done), 1);
    chk(cycles === e_cyc, f ? "R8 cycles" : (oc == 1 ? "R4 cycles" : (oc == 3 ? "R6 cycles" : "R3/R5/R7/R9 cycles")), 32'(cycles), 32'(e_cyc));
    chk(priv_fault === f, "R8 fault", 32'(priv_fault), 32'(f));
    chk(pc_adv === e_pc, "R7 pc_adv", 32'(pc_adv), 32'(e_pc));
    chk(sr === m_sr, "R10 sr", 32'(sr), 32'(m_sr));
    chk(usp === m_usp, "R6 usp", usp, m_usp);
    chk(wb_valid === e_wb, "R4/R6 wb_valid", 32'(wb_valid), 32'(e_wb));
    if (e_wb) begin
      chk(wb_data === e_wbd, "R4/R6 wb_data", wb_data, e_wbd);
      chk(wb_to_areg === e_an, "R6 wb_to_areg", 32'(wb_to_areg), 32'(e_an));
      chk(wb_reg === opw[2:0], "R6 wb_reg", 32'(wb_reg), 32'(opw[2:0]));
    end
  endtask

  initial begin
    rst_n = 0; start = 0; supervisor = 0; op_class = 0; opcode = 0; operand = 0; areg_in = 0; ea_cost = 0;
    m_sr = 16'h2700; m_usp = 0;
    repeat (3) @(negedge clk);
    chk(sr === 16'h2700, "R1 sr", 32'(sr), 32'h2700);
    chk(usp === 0, "R1 usp", usp, 0);
    chk(!done && !priv_fault && !wb_valid, "R1 flags", {29'h0, done, priv_fault, wb_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(done === 1'b0, "R2 idle", 32'(done), 0);
    for (int oc = 0; oc < 8; oc++)
      for (int s = 0; s < 2; s++)
        for (int md = 0; md < 8; md++)
          for (int ec = 0; ec < 16; ec += 5)
            for (int dr = 0; dr < 2; dr++)
              run_op(3'(oc), 16'(md * 8 + dr * 8 + (oc + md) % 8),
                     16'(16'h1357 * (md + 1) + 16'h0f0f * ec + oc * 16'h0a31),
                     1'(s), 32'h8000_0001 + 32'(oc * 32'h0101_0011 + md * 32'h77 + ec),
                     4'(ec));
    start = 0;
    @(negedge clk);
    chk(done === 1'b0, "R2 done single", 32'(done), 0);
    chk(sr === m_sr, "R9/R10 sr hold", 32'(sr), 32'(m_sr));
    run_op(3'd0, 16'h0000, 16'hffff, 1'b1, 0, 4'd15);
    run_op(3'd5, 16'h0000, 16'h0000, 1'b1, 0, 4'd0);
    run_op(3'd4, 16'h0000, 16'h00ff, 1'b1, 0, 4'd0);
    run_op(3'd2, 16'h0008, 16'hab5a, 1'b0, 0, 4'd3);
    run_op(3'd6, 16'h0000, 16'hffff, 1'b0, 0, 4'd0);
    run_op(3'd1, 16'h0000, 16'h0000, 1'b0, 0, 4'd9);
    start = 0;
    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R2 actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule